// File: doc/BRIEF.md
# Interrupt redirection table controller

This block takes a small set of interrupt input pins and turns each one into an interrupt message for a processor-side interrupt unit. Every pin has a redirection entry in two 32-bit words. The first word holds the vector, the delivery mode, the polarity, the trigger mode and a mask bit. The second word holds a 16-bit destination ID. Pins are synchronized and then detected either as edges (inactive-to-active transitions) or as levels, after polarity correction. The lowest-numbered eligible pin wins. The block offers one message at a time on a valid/ready port.

Software reaches the table through a select/window pair on a plain 32-bit register bus. It writes a register index to the select register, then reads or writes the window. A read-only identification register gives the version number and the highest entry index. A level-triggered pin that has been delivered stays in service until an end-of-interrupt input names its vector. One such input rearms every entry that uses that vector, which lets several level sources share a vector. An edge that arrives while its pin is masked is dropped, not held.

Top module: `irq_redir_ctrl`

## Requirements
- R1: After reset every entry's low word reads 0x0001_0000 (mask set, all else zero), every high word reads 0, and `msg_valid` is low.
- R2: Select index 0x01 reads the identification register: bits 7:0 hold `VERSION`, bits 23:16 hold `NUM_PINS-1`, and all other bits are zero.
- R3: `bus_addr`=0 addresses the select register and `bus_addr`=1 the window. Entry n's low word is at index 0x10+2n and its high word at 0x11+2n. The low word carries vector in 7:0, mode in 10:8, polarity in 13 (1 = active low), trigger in 15 (1 = level) and mask in 16. The high word carries the destination in 31:16. Every other bit, and any unused index, reads zero.
- R4: An unmasked edge pin creates exactly one message per inactive-to-active transition of its polarity-corrected input. Its pending state clears when that message is accepted.
- R5: An active edge that occurs while the pin's mask bit is set is discarded, and unmasking it later produces no message.
- R6: An unmasked level pin that is active produces a message. Once that message is accepted, the pin sends nothing more until an end-of-interrupt input carries its vector.
- R7: An end-of-interrupt input rearms every level entry whose vector equals the given vector. An input with a different vector leaves them in service.
- R8: When several pins are eligible at once, the lowest-numbered pin is delivered first.
- R9: While `msg_valid` is high and `msg_ready` is low, vector, mode and destination stay unchanged. After acceptance `msg_valid` is low for at least one cycle.
- R10: A message carries the vector, delivery mode and destination of the winning entry.
- R11: A level pin's message is valid on the third rising clock edge after the pin changes. An edge pin's message is valid on the fourth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pin | input | NUM_PINS | Asynchronous interrupt input pins |
| bus_addr | input | 1 | 0 = select register, 1 = data window |
| bus_wen | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector named by the end-of-interrupt |
| msg_valid | output | 1 | Interrupt message offered |
| msg_ready | input | 1 | Receiver takes the message |
| msg_vector | output | 8 | Message vector |
| msg_mode | output | 3 | Message delivery mode |
| msg_dest | output | 16 | Message destination ID |

## Verification
The two synchronizer flops set the latency. A level pin's message appears on the third edge after the pin moves, and an edge pin's message needs one more edge for the pending flop. The bench drives pins on the falling edge and confirms the message is still absent one edge early and present exactly on time. An acceptance or an end-of-interrupt takes effect at the next rising edge, so `msg_valid` is checked low at the following falling edge. The next winner is expected one edge after that. Checks that something must not happen wait at least five edges, which is longer than the longest path from pin to message.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

    localparam logic [7:0] SEL_VERSION    = 8'h01;
    localparam logic [7:0] SEL_ENTRY_BASE = 8'h10;

    typedef struct packed {
        logic       mask;
        logic       level;
        logic       act_low;
        logic [2:0] mode;
        logic [7:0] vector;
    } entry_cfg_t;

    typedef struct packed {
        logic [7:0]  vector;
        logic [2:0]  mode;
        logic [15:0] dest;
    } irq_msg_t;

    localparam entry_cfg_t CFG_RESET = '{mask: 1'b1, level: 1'b0, act_low: 1'b0,
                                         mode: 3'd0, vector: 8'd0};

    function automatic logic [31:0] cfg_to_word(entry_cfg_t c);
        return {15'd0, c.mask, c.level, 1'b0, c.act_low, 2'b00, c.mode, c.vector};
    endfunction

    function automatic entry_cfg_t word_to_cfg(logic [16:0] w);
        entry_cfg_t c;
        c.mask    = w[16];
        c.level   = w[15];
        c.act_low = w[13];
        c.mode    = w[10:8];
        c.vector  = w[7:0];
        return c;
    endfunction

endpackage

// File: rtl/irq_redir_pin.sv
module irq_redir_pin (
    input  logic       clk,
    input  logic       rst,
    input  logic       pin_in,
    input  logic       mask,
    input  logic       level,
    input  logic       act_low,
    input  logic [7:0] vector,
    input  logic       take,
    input  logic       eoi_valid,
    input  logic [7:0] eoi_vector,
    output logic       want
);
    logic sync1_q, sync2_q, prev_q, pend_q, insvc_q;
    logic active, rise, eoi_hit;

    assign active  = sync2_q ^ act_low;
    assign rise    = active & ~prev_q;
    assign eoi_hit = eoi_valid && (eoi_vector == vector);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            prev_q  <= 1'b0;
            pend_q  <= 1'b0;
            insvc_q <= 1'b0;
        end else begin
            sync1_q <= pin_in;
            sync2_q <= sync1_q;
            prev_q  <= active;
            if (level)
                pend_q <= 1'b0;
            else if (rise && !mask)
                pend_q <= 1'b1;
            else if (take)
                pend_q <= 1'b0;
            if (level && take)
                insvc_q <= 1'b1;
            else if (eoi_hit)
                insvc_q <= 1'b0;
        end
    end

    assign want = ~mask & (level ? (active & ~insvc_q) : pend_q);

    // R5: an edge seen under mask never becomes pending
    p_masked_edge_dropped_r5: assert property (@(posedge clk) disable iff (rst)
        (!level && mask && !pend_q) |=> !pend_q);

    // R6: in-service state survives until its own vector is ended
    p_in_service_kept_r6: assert property (@(posedge clk) disable iff (rst)
        (insvc_q && !eoi_hit) |=> insvc_q);

endmodule

// File: rtl/irq_redir_arb.sv
module irq_redir_arb #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--)
            if (req[i]) idx = IDX_W'(i);
    end

    assign any = |req;

    // R8: no requester below the chosen one
    p_lowest_first_r8: assert property (@(posedge clk) disable iff (rst)
        any |-> (req[idx] && ((req & ((N'(1) << idx) - N'(1))) == '0)));

endmodule

// File: rtl/irq_redir_ctrl.sv
module irq_redir_ctrl
    import irq_redir_pkg::*;
#(
    parameter int         NUM_PINS = 4,
    parameter logic [7:0] VERSION  = 8'h21
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] irq_pin,
    input  logic                bus_addr,
    input  logic                bus_wen,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic                eoi_valid,
    input  logic [7:0]          eoi_vector,
    output logic                msg_valid,
    input  logic                msg_ready,
    output logic [7:0]          msg_vector,
    output logic [2:0]          msg_mode,
    output logic [15:0]         msg_dest
);
    localparam int         PIN_W     = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
    localparam logic [7:0] MAX_INDEX = 8'(NUM_PINS - 1);

    logic [7:0]  sel_q;
    entry_cfg_t  cfg_q  [NUM_PINS];
    logic [15:0] dest_q [NUM_PINS];

    logic [7:0] sel_off;
    logic [6:0] sel_idx;
    logic       sel_entry;
    logic       unused_wdata;

    assign sel_off      = sel_q - SEL_ENTRY_BASE;
    assign sel_idx      = sel_off[7:1];
    assign sel_entry    = (sel_q >= SEL_ENTRY_BASE) && (sel_idx < 7'(NUM_PINS));
    assign unused_wdata = ^bus_wdata;

    // register writes through the select/window pair
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            for (int i = 0; i < NUM_PINS; i++) begin
                cfg_q[i]  <= CFG_RESET;
                dest_q[i] <= '0;
            end
        end else if (bus_wen) begin
            if (!bus_addr)
                sel_q <= bus_wdata[7:0];
            else
                for (int i = 0; i < NUM_PINS; i++)
                    if (sel_entry && sel_idx == 7'(i)) begin
                        if (sel_off[0]) dest_q[i] <= bus_wdata[31:16];
                        else            cfg_q[i]  <= word_to_cfg(bus_wdata[16:0]);
                    end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (!bus_addr)
            bus_rdata = {24'd0, sel_q};
        else if (sel_q == SEL_VERSION)
            bus_rdata = {8'd0, MAX_INDEX, 8'd0, VERSION};
        else if (sel_entry)
            for (int i = 0; i < NUM_PINS; i++)
                if (sel_idx == 7'(i))
                    bus_rdata = sel_off[0] ? {dest_q[i], 16'd0} : cfg_to_word(cfg_q[i]);
    end

    // per-pin detection
    logic [NUM_PINS-1:0] want, take, mask_vec;
    logic                msg_valid_q;
    logic [PIN_W-1:0]    msg_pin_q;
    irq_msg_t            msg_q;

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        assign mask_vec[g] = cfg_q[g].mask;
        assign take[g]     = msg_valid_q && msg_ready && (msg_pin_q == PIN_W'(g));
        irq_redir_pin u_pin (
            .clk        (clk),
            .rst        (rst),
            .pin_in     (irq_pin[g]),
            .mask       (cfg_q[g].mask),
            .level      (cfg_q[g].level),
            .act_low    (cfg_q[g].act_low),
            .vector     (cfg_q[g].vector),
            .take       (take[g]),
            .eoi_valid  (eoi_valid),
            .eoi_vector (eoi_vector),
            .want       (want[g])
        );
    end

    logic             win_any;
    logic [PIN_W-1:0] win_idx;

    irq_redir_arb #(.N(NUM_PINS), .IDX_W(PIN_W)) u_arb (
        .clk (clk),
        .rst (rst),
        .req (want),
        .any (win_any),
        .idx (win_idx)
    );

    // delivery register: one message at a time
    always_ff @(posedge clk) begin
        if (rst) begin
            msg_valid_q <= 1'b0;
            msg_pin_q   <= '0;
            msg_q       <= '0;
        end else if (msg_valid_q && msg_ready) begin
            msg_valid_q <= 1'b0;
        end else if (!msg_valid_q && win_any) begin
            msg_valid_q <= 1'b1;
            msg_pin_q   <= win_idx;
            msg_q       <= '{vector: cfg_q[win_idx].vector,
                             mode:   cfg_q[win_idx].mode,
                             dest:   dest_q[win_idx]};
        end
    end

    assign msg_valid  = msg_valid_q;
    assign msg_vector = msg_q.vector;
    assign msg_mode   = msg_q.mode;
    assign msg_dest   = msg_q.dest;

    // R1: first cycle out of reset has every pin masked
    p_reset_masked_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (&mask_vec && !msg_valid));

    // R9: offered message held stable under backpressure
    p_hold_stable_r9: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vector)
                                       && $stable(msg_mode) && $stable(msg_dest)));

    // R9: gap after each acceptance
    p_release_gap_r9: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_ready) |=> !msg_valid);

endmodule

// File: tb/irq_redir_ctrl_test.sv
`timescale 1ns/1ps
module irq_redir_ctrl_test;
    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [N-1:0] irq_pin = 4'b1100;
    logic        bus_addr = 1'b0, bus_wen = 1'b0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        eoi_valid = 1'b0;
    logic [7:0]  eoi_vector = '0;
    logic        msg_valid, msg_ready = 1'b0;
    logic [7:0]  msg_vector;
    logic [2:0]  msg_mode;
    logic [15:0] msg_dest;

    int errors = 0, checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_redir_ctrl #(.NUM_PINS(N), .VERSION(8'h21)) uut (
        .clk(clk), .rst(rst), .irq_pin(irq_pin),
        .bus_addr(bus_addr), .bus_wen(bus_wen), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
        .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_vector(msg_vector), .msg_mode(msg_mode), .msg_dest(msg_dest)
    );

    // rows: {pin, destination, low word}
    localparam logic [47:0] ROWS [4] = '{
        {8'd0, 16'h0102, 24'h000031},   // edge, active high, mode 0
        {8'd1, 16'h0A0B, 24'h008142},   // level, active high, mode 1
        {8'd2, 16'h1234, 24'h002455},   // edge, active low, mode 4
        {8'd3, 16'hFFEE, 24'h00A566}    // level, active low, mode 5
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic prog(input logic [7:0] s, input logic [31:0] d);
        wr(1'b0, {24'd0, s});
        wr(1'b1, d);
    endtask

    task automatic rd(input logic [7:0] s, output logic [31:0] d);
        wr(1'b0, {24'd0, s});
        bus_addr = 1'b1;
        #1 d = bus_rdata;
    endtask

    task automatic accept();
        msg_ready = 1'b1;
        tick(1);
        msg_ready = 1'b0;
    endtask

    task automatic eoi(input logic [7:0] v);
        eoi_valid = 1'b1; eoi_vector = v;
        tick(1);
        eoi_valid = 1'b0;
    endtask

    initial begin
        logic [31:0] rv;
        tick(3);
        rst = 1'b0;
        // reset state
        chk(!msg_valid, "R1", 32'(msg_valid), 0);
        rd(8'h10, rv); chk(rv == 32'h0001_0000, "R1", rv, 32'h0001_0000);
        rd(8'h16, rv); chk(rv == 32'h0001_0000, "R1", rv, 32'h0001_0000);
        rd(8'h11, rv); chk(rv == 32'h0, "R1", rv, 0);
        rd(8'h01, rv); chk(rv == 32'h0003_0021, "R2", rv, 32'h0003_0021);
        rd(8'h20, rv); chk(rv == 32'h0, "R3", rv, 0);
        prog(8'h13, 32'hFFFF_FFFF);
        rd(8'h13, rv); chk(rv == 32'hFFFF_0000, "R3", rv, 32'hFFFF_0000);
        prog(8'h14, 32'hFFFF_FFFF);
        rd(8'h14, rv); chk(rv == 32'h0001_A7FF, "R3", rv, 32'h0001_A7FF);
        bus_addr = 1'b0; #1 chk(bus_rdata == 32'h14, "R3", bus_rdata, 32'h14);
        prog(8'h14, 32'h0001_0000);
        prog(8'h13, 32'h0);
        tick(5);
        chk(!msg_valid, "R3", 32'(msg_valid), 0);

        // table walk: one pin per row
        for (int r = 0; r < 4; r++) begin
            int p, lat;
            logic [15:0] d;
            logic [23:0] lo;
            logic lvl, al;
            p = int'(ROWS[r][47:40]); d = ROWS[r][39:24]; lo = ROWS[r][23:0];
            lvl = lo[15]; al = lo[13]; lat = lvl ? 3 : 4;
            prog(8'(8'h11 + 2 * p), {d, 16'd0});
            prog(8'(8'h10 + 2 * p), {8'd0, lo});
            tick(2);
            irq_pin[p] = ~al;
            tick(lat - 1);
            chk(!msg_valid, "R11", 32'(msg_valid), 0);
            tick(1);
            chk(msg_valid, "R11", 32'(msg_valid), 1);
            chk(msg_vector == lo[7:0], "R10", 32'(msg_vector), 32'(lo[7:0]));
            chk(msg_mode == lo[10:8], "R10", 32'(msg_mode), 32'(lo[10:8]));
            chk(msg_dest == d, "R10", 32'(msg_dest), 32'(d));
            accept();
            chk(!msg_valid, "R9", 32'(msg_valid), 0);
            tick(5);
            chk(!msg_valid, lvl ? "R6" : "R4", 32'(msg_valid), 0);
            irq_pin[p] = al;
            tick(3);
            if (lvl) eoi(lo[7:0]);
            tick(5);
            chk(!msg_valid, "R6", 32'(msg_valid), 0);
            prog(8'(8'h10 + 2 * p), {8'd0, lo} | 32'h0001_0000);
        end

        // masked edge dropped
        prog(8'h10, 32'h0001_0031);
        irq_pin[0] = 1'b1; tick(6);
        irq_pin[0] = 1'b0; tick(3);
        prog(8'h10, 32'h0000_0031);
        tick(6);
        chk(!msg_valid, "R5", 32'(msg_valid), 0);
        irq_pin[0] = 1'b1; tick(4);
        chk(msg_valid && msg_vector == 8'h31, "R4", 32'(msg_vector), 32'h31);
        accept();
        irq_pin[0] = 1'b0;
        prog(8'h10, 32'h0001_0031);
        tick(5);

        // shared level vector on pins 1 and 3
        prog(8'h13, 32'h0001_0000); prog(8'h12, 32'h0000_8077);
        prog(8'h17, 32'h0003_0000); prog(8'h16, 32'h0000_A077);
        irq_pin[1] = 1'b1; irq_pin[3] = 1'b0;
        tick(3);
        chk(msg_valid && msg_dest == 16'h0001, "R8", 32'(msg_dest), 32'h1);
        tick(3);
        chk(msg_valid && msg_vector == 8'h77 && msg_dest == 16'h0001, "R9", 32'(msg_dest), 32'h1);
        accept();
        chk(!msg_valid, "R9", 32'(msg_valid), 0);
        tick(1);
        chk(msg_valid && msg_dest == 16'h0003, "R8", 32'(msg_dest), 32'h3);
        accept();
        tick(5);
        chk(!msg_valid, "R6", 32'(msg_valid), 0);
        eoi(8'h76);
        tick(5);
        chk(!msg_valid, "R7", 32'(msg_valid), 0);
        eoi(8'h77);
        tick(1);
        chk(msg_valid && msg_dest == 16'h0001, "R7", 32'(msg_dest), 32'h1);
        accept();
        tick(1);
        chk(msg_valid && msg_dest == 16'h0003, "R7", 32'(msg_dest), 32'h3);
        accept();
        tick(3);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1..all actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule